// File: doc/BRIEF.md
# Two-Channel PWM Action Qualifier

This block generates two pulse-width-modulated outputs from one shared time-base counter. A clock prescaler sets the counter's tick rate, and the counter runs from zero up to a programmed top value. In the optional up-down mode it climbs to the top and then falls back to zero. Each channel has its own compare value and its own action word. On every tick the block finds which counter events are present: zero, top (period match), compare while rising, and compare while falling. The channel's action word then says whether the output is set, cleared, toggled or left alone.

Software programs the block through a flat register port. Writes land on the clock edge when `wr_en_i` is high, and reads are combinational on `addr_i`. The period and compare registers are double-buffered. A new value reaches the counter only when it wraps to zero, so the running cycle always completes. A per-channel force field pins an output high or low over the action result, while the qualifier state keeps running underneath.

Top module: `pwm_aq_top`

Register map (word addresses):

| Address | Contents |
|---|---|
| 0 | top value P, full width |
| 1 | prescaler and mode: [2:0] power-of-two stage K, [5:3] fast stage H, [6] up-down mode |
| 2 | channel A compare value |
| 3 | channel B compare value |
| 4 | channel A action word |
| 5 | channel B action word |
| 6 | force fields: [1:0] channel A, [3:2] channel B |
| 7 | reads 0 |

Action word fields: [1:0] zero event, [3:2] top event, [5:4] compare while rising, [7:6] compare while falling. Each field codes 00 none, 01 drive low, 10 drive high, 11 toggle. Force codes: 00 off, 01 low, 10 high, 11 off.

## Requirements
- R1: In count-up mode the output period is (P+1)·D clock cycles, where D = 2^K · (H==0 ? 1 : 2·H).
- R2: With action word 0x52 (zero sets high, both compares clear low) and compare C in 1..P, a channel is high for C·D cycles in each period. Channel A uses address 2 and address 4; channel B uses address 3 and address 5.
- R3: With action word 0xA1 (zero clears low, both compares set high) and C in 1..P, a channel is high for (P+1−C)·D cycles in each period.
- R4: With a compare value above P, the compare never matches. The output holds the level set by the zero event and shows no edges.
- R5: When several events fall on one tick, the highest-priority event whose field is non-zero decides. Compare outranks top, and top outranks zero. With C=0 and word 0x52 the output stays low; with C=P and word 0x1A it is high for P·D cycles.
- R6: Field code 11 inverts the output on its event. Toggling on zero alone gives a 50 % wave with period 2·(P+1)·D.
- R7: Writes to P or to a compare value take effect only when the counter next wraps to zero. The cycle in progress keeps its old length.
- R8: In up-down mode (bit 6 set) the period is 2·P·D cycles. With word 0x60 (rising compare sets high, falling compare clears low) the high time is 2·(P−C)·D.
- R9: Force code 10 holds the output high and 01 holds it low. Codes 00 and 11 pass the action result through, so edges resume.
- R10: A channel whose action word is zero never changes level.
- R11: Every register reads back what was written, with unimplemented bits returning 0.
- R12: After reset both outputs are low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | ADDR_W | register word address |
| wdata_i | input | DATA_W | write data |
| rdata_o | output | DATA_W | read data for addr_i |
| pwm_a_o | output | 1 | channel A output |
| pwm_b_o | output | 1 | channel B output |

## Verification
The bench measures the high time and the period at the outputs, in clock cycles. It sweeps two top values, every compare value from 1 to P and five prescaler settings. Channel A runs the normal word and channel B the inverted word, so a wrong divider factor, an off-by-one at the wrap and a swapped polarity each show up as distinct errors. Further patterns place events on the same tick (C=0, C=P) and push the compare past the top value. Other patterns toggle on a single event, run in up-down mode, change P in the middle of a cycle and step through every force code. Each of these separates one ordering or override rule from the others.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int NUM_CH   = 2;
  localparam int CLKPOW_W = 3;
  localparam int HSDIV_W  = 3;
  localparam int ACT_W    = 8;
  localparam int FRC_W    = 2;

  localparam int unsigned ADR_PRD  = 0;
  localparam int unsigned ADR_CTRL = 1;
  localparam int unsigned ADR_CMP0 = 2;
  localparam int unsigned ADR_ACT0 = 4;
  localparam int unsigned ADR_FRC  = 6;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;

  typedef enum logic [1:0] {
    FRC_OFF  = 2'b00,
    FRC_LOW  = 2'b01,
    FRC_HIGH = 2'b10,
    FRC_RSV  = 2'b11
  } frc_e;

  // packed MSB first: falling compare, rising compare, top, zero
  typedef struct packed {
    act_e cdn;
    act_e cup;
    act_e prd;
    act_e zro;
  } act_word_t;

  typedef struct packed {
    logic zro;
    logic prd;
    logic cup;
    logic cdn;
  } evt_t;

endpackage

// File: rtl/pwm_aq_regs.sv
module pwm_aq_regs
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic [CNT_W-1:0]                 prd_o,
  output logic [CLKPOW_W-1:0]              clk_pow_o,
  output logic [HSDIV_W-1:0]               hs_div_o,
  output logic                             updown_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]     cmp_o,
  output act_word_t [NUM_CH-1:0]           act_o,
  output frc_e [NUM_CH-1:0]                frc_o
);

  localparam int HS_LSB = CLKPOW_W;
  localparam int UD_BIT = CLKPOW_W + HSDIV_W;

  logic wr_prd, wr_ctrl, wr_frc;

  assign wr_prd  = wr_en_i && (addr_i == ADDR_W'(ADR_PRD));
  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(ADR_CTRL));
  assign wr_frc  = wr_en_i && (addr_i == ADDR_W'(ADR_FRC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prd_o     <= '0;
      clk_pow_o <= '0;
      hs_div_o  <= '0;
      updown_o  <= 1'b0;
    end else begin
      if (wr_prd) prd_o <= wdata_i[CNT_W-1:0];
      if (wr_ctrl) begin
        clk_pow_o <= wdata_i[CLKPOW_W-1:0];
        hs_div_o  <= wdata_i[HS_LSB +: HSDIV_W];
        updown_o  <= wdata_i[UD_BIT];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch_regs
    logic wr_cmp, wr_act;
    assign wr_cmp = wr_en_i && (addr_i == ADDR_W'(ADR_CMP0 + ch));
    assign wr_act = wr_en_i && (addr_i == ADDR_W'(ADR_ACT0 + ch));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_o[ch] <= '0;
        act_o[ch] <= '0;
        frc_o[ch] <= FRC_OFF;
      end else begin
        if (wr_cmp) cmp_o[ch] <= wdata_i[CNT_W-1:0];
        if (wr_act) act_o[ch] <= act_word_t'(wdata_i[ACT_W-1:0]);
        if (wr_frc) frc_o[ch] <= frc_e'(wdata_i[FRC_W*ch +: FRC_W]);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADR_PRD)) rdata_o = DATA_W'(prd_o);
    if (addr_i == ADDR_W'(ADR_CTRL)) rdata_o = DATA_W'({updown_o, hs_div_o, clk_pow_o});
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr_i == ADDR_W'(ADR_CMP0 + ch)) rdata_o = DATA_W'(cmp_o[ch]);
      if (addr_i == ADDR_W'(ADR_ACT0 + ch)) rdata_o = DATA_W'(act_o[ch]);
      if (addr_i == ADDR_W'(ADR_FRC)) rdata_o[FRC_W*ch +: FRC_W] = frc_o[ch];
    end
  end

endmodule

// File: rtl/pwm_aq_prescale.sv
module pwm_aq_prescale
  import pwm_aq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CLKPOW_W-1:0] clk_pow_i,
  input  logic [HSDIV_W-1:0]  hs_div_i,
  output logic                tick_o
);

  // largest divisor: (2*(2^HSDIV_W-1)) << (2^CLKPOW_W-1)
  localparam int PS_W = HSDIV_W + 1 + (1 << CLKPOW_W) - 1;

  logic [HSDIV_W:0] hs_fac;
  logic [PS_W-1:0]  div, ps_cnt_q;

  assign hs_fac = (hs_div_i == '0) ? (HSDIV_W + 1)'(1) : {hs_div_i, 1'b0};
  assign div    = PS_W'(hs_fac) << clk_pow_i;
  assign tick_o = (ps_cnt_q >= div - PS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ps_cnt_q <= '0;
    else if (tick_o) ps_cnt_q <= '0;
    else             ps_cnt_q <= ps_cnt_q + PS_W'(1);
  end

endmodule

// File: rtl/pwm_aq_timebase.sv
module pwm_aq_timebase
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic                         updown_i,
  input  logic [CNT_W-1:0]             prd_shd_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_shd_i,
  output logic [CNT_W-1:0]             cnt_o,
  output logic [CNT_W-1:0]             prd_act_o,
  output evt_t [NUM_CH-1:0]            evt_o
);

  logic [CNT_W-1:0]             cnt_q, cnt_d, prd_q;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
  logic                         up_q, up_d;
  logic                         at_top, at_zero, load;

  assign at_top  = (cnt_q >= prd_q);
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (!updown_i) begin
      up_d  = 1'b1;
      cnt_d = at_top ? '0 : cnt_q + CNT_W'(1);
    end else if (up_q) begin
      if (at_top) begin
        up_d  = 1'b0;
        cnt_d = (prd_q == '0) ? '0 : prd_q - CNT_W'(1);
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end else begin
      if (at_zero) begin
        up_d  = 1'b1;
        cnt_d = (prd_q == '0) ? '0 : CNT_W'(1);
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  // shadow transfer on the tick that returns the counter to zero
  assign load = tick_i && (cnt_d == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      prd_q <= '0;
      cmp_q <= '0;
    end else begin
      if (tick_i) begin
        cnt_q <= cnt_d;
        up_q  <= up_d;
      end
      if (load) begin
        prd_q <= prd_shd_i;
        cmp_q <= cmp_shd_i;
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_evt
    logic hit;
    assign hit            = (cnt_q == cmp_q[ch]);
    assign evt_o[ch].zro  = at_zero;
    assign evt_o[ch].prd  = (cnt_q == prd_q);
    assign evt_o[ch].cup  = hit && up_q;
    assign evt_o[ch].cdn  = hit && !up_q;
  end

  assign cnt_o     = cnt_q;
  assign prd_act_o = prd_q;

endmodule

// File: rtl/pwm_aq_qual.sv
module pwm_aq_qual
  import pwm_aq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  evt_t      evt_i,
  input  act_word_t act_i,
  input  frc_e      frc_i,
  output logic      lvl_o,
  output logic      pwm_o
);

  act_e sel;
  logic lvl_d, lvl_q;

  // later assignments win: compare > top > zero
  always_comb begin
    sel = ACT_NONE;
    if (evt_i.zro && act_i.zro != ACT_NONE) sel = act_i.zro;
    if (evt_i.prd && act_i.prd != ACT_NONE) sel = act_i.prd;
    if (evt_i.cup && act_i.cup != ACT_NONE) sel = act_i.cup;
    if (evt_i.cdn && act_i.cdn != ACT_NONE) sel = act_i.cdn;
  end

  always_comb begin
    case (sel)
      ACT_LOW:  lvl_d = 1'b0;
      ACT_HIGH: lvl_d = 1'b1;
      ACT_TOG:  lvl_d = ~lvl_q;
      default:  lvl_d = lvl_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lvl_q <= 1'b0;
    else if (tick_i) lvl_q <= lvl_d;
  end

  always_comb begin
    case (frc_i)
      FRC_LOW:  pwm_o = 1'b0;
      FRC_HIGH: pwm_o = 1'b1;
      default:  pwm_o = lvl_q;
    endcase
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/pwm_aq_top.sv
module pwm_aq_top
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_a_o,
  output logic              pwm_b_o
);

  logic [CNT_W-1:0]             prd_shd, prd_act, tb_cnt;
  logic [CLKPOW_W-1:0]          clk_pow;
  logic [HSDIV_W-1:0]           hs_div;
  logic                         updown, tick;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_shd;
  act_word_t [NUM_CH-1:0]       act;
  frc_e [NUM_CH-1:0]            frc;
  evt_t [NUM_CH-1:0]            evt;
  logic [NUM_CH-1:0]            aq_lvl, pwm;

  pwm_aq_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .prd_o     (prd_shd),
    .clk_pow_o (clk_pow),
    .hs_div_o  (hs_div),
    .updown_o  (updown),
    .cmp_o     (cmp_shd),
    .act_o     (act),
    .frc_o     (frc)
  );

  pwm_aq_prescale u_prescale (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_pow_i (clk_pow),
    .hs_div_i  (hs_div),
    .tick_o    (tick)
  );

  pwm_aq_timebase #(.CNT_W(CNT_W)) u_timebase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .updown_i  (updown),
    .prd_shd_i (prd_shd),
    .cmp_shd_i (cmp_shd),
    .cnt_o     (tb_cnt),
    .prd_act_o (prd_act),
    .evt_o     (evt)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_qual
    pwm_aq_qual u_qual (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .evt_i  (evt[ch]),
      .act_i  (act[ch]),
      .frc_i  (frc[ch]),
      .lvl_o  (aq_lvl[ch]),
      .pwm_o  (pwm[ch])
    );
  end

  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];

endmodule

// File: rtl/pwm_aq_checker.sv
module pwm_aq_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             updown_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] prd_act_i,
  input logic [7:0]       act_a_i,
  input logic [1:0]       frc_a_i,
  input logic             lvl_a_i,
  input logic             pwm_a_i
);

  assert_cnt_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= prd_act_i);

  assert_up_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !updown_i && cnt_i < prd_act_i) |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  assert_shadow_at_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prd_act_i) |-> cnt_i == '0);

  assert_hold_between_ticks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(lvl_a_i));

  assert_disabled_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_a_i == '0) |=> $stable(lvl_a_i));

  assert_force_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_a_i == 2'b10) |-> pwm_a_i);

  assert_force_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frc_a_i == 2'b01) |-> !pwm_a_i);

endmodule

bind pwm_aq_top pwm_aq_checker #(.CNT_W(CNT_W)) u_pwm_aq_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick),
  .updown_i  (updown),
  .cnt_i     (tb_cnt),
  .prd_act_i (prd_act),
  .act_a_i   (act[0]),
  .frc_a_i   (frc[0]),
  .lvl_a_i   (aq_lvl[0]),
  .pwm_a_i   (pwm_a_o)
);

// File: tb/pwm_aq_top_bench.sv
`timescale 1ns/1ps
module pwm_aq_top_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pwm_a, pwm_b;

  always #4 clk = ~clk;

  pwm_aq_top u_pwm_aq_top (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pwm_a_o (pwm_a),
    .pwm_b_o (pwm_b)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int rise_prev[2] = '{0, 0};
  int rise_last[2] = '{0, 0};
  int fall_last[2] = '{0, 0};
  int rise_n[2]    = '{0, 0};
  int fall_n[2]    = '{0, 0};
  logic prev_lvl[2] = '{1'b0, 1'b0};
  logic [1:0] pwm_v;

  assign pwm_v = {pwm_b, pwm_a};

  // edge timestamps in clock cycles, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    for (int ch = 0; ch < 2; ch++) begin
      if (!pwm_v[ch] && prev_lvl[ch]) begin
        fall_last[ch] = cyc;
        fall_n[ch]++;
      end
      if (pwm_v[ch] && !prev_lvl[ch]) begin
        rise_prev[ch] = rise_last[ch];
        rise_last[ch] = cyc;
        rise_n[ch]++;
      end
      prev_lvl[ch] = pwm_v[ch];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr  = a[2:0];
    wdata = d[15:0];
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = a[2:0];
    #1;
    d = int'(rdata);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic cfg(input int prd, input int clkp, input int hs, input int ud,
                     input int ca, input int cb, input int aa, input int ab);
    do_reset();
    wr(1, clkp | (hs << 3) | (ud << 6));
    wr(2, ca);
    wr(3, cb);
    wr(4, aa);
    wr(5, ab);
    wr(0, prd);
  endtask

  task automatic measure(input int ch, output int hi, output int per);
    int b;
    b = rise_n[ch];
    wait (rise_n[ch] >= b + 3);
    hi  = fall_last[ch] - rise_prev[ch];
    per = rise_last[ch] - rise_prev[ch];
  endtask

  task automatic expect_const(input int ch, input int lvl, input int n, input string req);
    int br, bf;
    repeat (n) @(negedge clk);
    br = rise_n[ch];
    bf = fall_n[ch];
    repeat (n) @(negedge clk);
    check(req, (rise_n[ch] - br) + (fall_n[ch] - bf), 0);
    if (lvl >= 0) check(req, int'(pwm_v[ch]), lvl);
  endtask

  function automatic int div_of(input int clkp, input int hs);
    return (1 << clkp) * ((hs == 0) ? 1 : 2 * hs);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end

  int dc_p[5] = '{0, 1, 0, 2, 1};
  int dc_h[5] = '{0, 0, 1, 2, 3};
  int exp_rb[8] = '{65535, 127, 65535, 65535, 255, 255, 15, 0};

  initial begin
    int v, hi, per, d, r0;
    do_reset();

    // R12: reset state
    check("R12 pwm_a after reset", int'(pwm_a), 0);
    check("R12 pwm_b after reset", int'(pwm_b), 0);
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check("R12 register reset value", v, 0);
    end

    // R11: readback with masking
    for (int a = 0; a < 8; a++) wr(a, 16'hFFFF);
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check("R11 readback", v, exp_rb[a]);
    end

    // R1 R2 R3: sweep of top, compare and prescaler
    for (int p = 3; p <= 5; p += 2) begin
      for (int k = 0; k < 5; k++) begin
        d = div_of(dc_p[k], dc_h[k]);
        for (int c = 1; c <= p; c++) begin
          cfg(p, dc_p[k], dc_h[k], 0, c, c, 8'h52, 8'hA1);
          measure(0, hi, per);
          check("R2 normal high time", hi, c * d);
          check("R1 period ch A", per, (p + 1) * d);
          measure(1, hi, per);
          check("R3 inverted high time", hi, (p + 1 - c) * d);
          check("R1 period ch B", per, (p + 1) * d);
        end
      end
    end

    // R4: compare beyond top
    cfg(4, 0, 0, 0, 6, 5, 8'h52, 8'hA1);
    expect_const(0, 1, 20, "R4 normal, compare > top");
    expect_const(1, 0, 20, "R4 inverted, compare > top");

    // R5: same-tick priority
    cfg(4, 0, 0, 0, 0, 4, 8'h52, 8'h1A);
    expect_const(0, 0, 20, "R5 compare beats zero");
    measure(1, hi, per);
    check("R5 compare beats top", hi, 4);
    check("R5 period", per, 5);

    // R6: toggle on zero
    cfg(3, 1, 0, 0, 9, 9, 8'h03, 8'h03);
    measure(0, hi, per);
    check("R6 toggle high time", hi, 8);
    check("R6 toggle period", per, 16);

    // R7: shadowed top value
    cfg(7, 0, 0, 0, 2, 2, 8'h52, 8'h52);
    v = rise_n[0];
    wait (rise_n[0] >= v + 2);
    r0 = rise_last[0];
    wr(0, 3);
    wait (rise_n[0] >= v + 4);
    check("R7 running cycle kept", rise_prev[0] - r0, 8);
    check("R7 new period after wrap", rise_last[0] - rise_prev[0], 4);

    // R8: up-down mode
    cfg(6, 0, 0, 1, 2, 4, 8'h60, 8'h60);
    measure(0, hi, per);
    check("R8 up-down high A", hi, 8);
    check("R8 up-down period A", per, 12);
    measure(1, hi, per);
    check("R8 up-down high B", hi, 4);
    cfg(6, 1, 0, 1, 2, 4, 8'h60, 8'h60);
    measure(0, hi, per);
    check("R8 up-down high div2", hi, 16);
    check("R8 up-down period div2", per, 24);

    // R9: force
    cfg(4, 0, 0, 0, 2, 2, 8'h52, 8'h52);
    wr(6, 16'h0002);
    expect_const(0, 1, 20, "R9 force high A");
    measure(1, hi, per);
    check("R9 unforced B runs", hi, 2);
    wr(6, 16'h0004);
    expect_const(1, 0, 20, "R9 force low B");
    measure(0, hi, per);
    check("R9 released A runs", hi, 2);
    wr(6, 16'h000F);
    measure(0, hi, per);
    check("R9 reserved code passes A", hi, 2);
    measure(1, hi, per);
    check("R9 reserved code passes B", hi, 2);

    // R10: zero action word
    cfg(4, 0, 0, 0, 2, 2, 8'h52, 8'h00);
    expect_const(1, 0, 20, "R10 disabled channel B");
    wr(4, 0);
    expect_const(0, -1, 20, "R10 disabled after running A");

    summary();
    $finish;
  end

endmodule